// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block gathers every interrupt cause of a serial port into a single interrupt line and an identification byte that software reads to learn which cause is being served. Its inputs are the status signals of the receiver, the transmitter and the modem-control logic: line errors, data ready, receive queue level and its trigger threshold, a character-timeout flag, transmit-holding-empty events, and the modem delta bits. The queues, the shift registers and the baud generator live elsewhere.

Software reaches the block through strobes. One strobe writes the 4-bit enable register. Another marks a read of the identification byte. The block keeps its own transmit-empty pending latch. That latch is armed when the holding register drains and disarmed when it is refilled. Reading the identification byte while it reports transmit-empty also disarms it, and turning the transmit-empty enable on re-arms it. This reproduces the one-shot behaviour drivers rely on.

The identification byte and the interrupt line are both registered. They follow any input change one clock later.

Top module: `uart_irq_arbiter`

## Requirements
- R1: When several causes are active and enabled, the identification code shows the highest one. The order, highest first, is: line status (enable bit 2, any of the four error inputs), character timeout (enable bit 0), receive data (enable bit 0), transmit-empty pending (enable bit 1), modem change (enable bit 3, any delta input).
- R2: The identification low nibble is 0x6 for line status, 0xC for timeout, 0x4 for receive data, 0x2 for transmit-empty, 0x0 for modem change and 0x1 when nothing is pending.
- R3: With queue mode on, receive data counts as a cause only while the queue level is at least the trigger level. With queue mode off, data ready alone is enough.
- R4: Identification bits 7:6 read 11 while queue mode is on and 00 while it is off. Bits 5:4 read 0.
- R5: A read strobe of the identification byte while it shows 0x2 clears the transmit-empty pending latch.
- R6: An enable write that flips enable bit 1 sets the pending latch if the new bit is 1 and the holding register is empty, and clears the latch otherwise. An enable write that leaves bit 1 unchanged does not touch the latch.
- R7: A holding-register write clears the pending latch and a became-empty pulse sets it. In one cycle the precedence, lowest to highest, is: read clear, enable write, holding write, became-empty.
- R8: Only enable bits 3:0 store write data. The enable readback has bits 7:4 at zero.
- R9: The interrupt output is high exactly when the identification low nibble is not 0x1. Both follow the inputs one clock later.
- R10: Reset gives enable 0x00, identification 0x01, pending latch clear and interrupt low.
- R11: The character-timeout cause is masked when enable bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr_en | input | 1 | Enable-register write strobe |
| ier_wr_data | input | 8 | Enable-register write data |
| iid_rd_en | input | 1 | Identification-byte read strobe |
| fifo_mode | input | 1 | Queue mode is on |
| line_err | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receiver holds data |
| rx_level | input | RX_CNT_W | Receive queue fill level |
| rx_trigger | input | RX_CNT_W | Receive trigger threshold |
| char_tmo | input | 1 | Character-timeout pending |
| thr_write | input | 1 | Holding register written this cycle |
| thr_empty | input | 1 | Holding register is empty |
| thr_empty_set | input | 1 | Holding register became empty this cycle |
| modem_delta | input | 4 | Modem status change flags |
| ier_rdata | output | 8 | Enable-register readback |
| iid_rdata | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check the following on every cycle:
- the stored enable value after each write;
- the agreement of the interrupt line with the identification nibble;
- the queue-mode bits;
- the dominance of an enabled line error;
- the timeout and receive-data masking;
- the direct effects of holding writes, became-empty pulses and read clears on the pending latch.

Only the bench scenarios can show the rest. These cover the full priority ladder as causes are removed one at a time, the trigger-level threshold at, below and above its value, and the re-arming of the latch by an enable flip with the holding register full or empty. In each scenario a behavioural reference model is compared against the design every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    SRC_MODEM   = 4'h0,
    SRC_NONE    = 4'h1,
    SRC_THRE    = 4'h2,
    SRC_RXDATA  = 4'h4,
    SRC_LINE    = 4'h6,
    SRC_TIMEOUT = 4'hC
  } irq_src_e;

  localparam int unsigned EN_W      = 4;
  localparam int unsigned EN_RX     = 0;
  localparam int unsigned EN_THRE   = 1;
  localparam int unsigned EN_LINE   = 2;
  localparam int unsigned EN_MODEM  = 3;
  localparam int unsigned NUM_SRC   = 5;

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [EN_W-1:0] wr_data,
  input  logic            rd_clr,
  input  logic            thr_write,
  input  logic            thr_empty,
  input  logic            thr_empty_set,
  output logic [EN_W-1:0] en_q,
  output logic            pend_q
);

  logic [EN_W-1:0] en_d;
  logic            pend_d;
  logic            thre_flip;

  assign thre_flip = wr_en && (wr_data[EN_THRE] != en_q[EN_THRE]);

  // next state: later statements take precedence
  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (wr_en)
      en_d = wr_data;
    if (rd_clr)
      pend_d = 1'b0;
    if (thre_flip)
      pend_d = wr_data[EN_THRE] & thr_empty;
    if (thr_write)
      pend_d = 1'b0;
    if (thr_empty_set)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en)
        en_q <= en_d;
      pend_q <= pend_d;
    end
  end

  p_wr_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == $past(wr_data));

  p_thr_write_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_write && !thr_empty_set) |=> !pend_q);

  p_empty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_empty_set |=> pend_q);

  p_rd_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_en && !thr_empty_set) |=> !pend_q);

  p_flip_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_flip && !thr_empty && !thr_empty_set) |=> !pend_q);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned RX_CNT_W = 5,
  parameter int unsigned ERR_W    = 4,
  parameter int unsigned DELTA_W  = 4
) (
  input  logic [EN_W-1:0]     en,
  input  logic                thre_pend,
  input  logic [ERR_W-1:0]    line_err,
  input  logic                data_ready,
  input  logic                fifo_mode,
  input  logic [RX_CNT_W-1:0] rx_level,
  input  logic [RX_CNT_W-1:0] rx_trigger,
  input  logic                char_tmo,
  input  logic [DELTA_W-1:0]  modem_delta,
  output irq_src_e            code
);

  logic [NUM_SRC-1:0] req;
  irq_src_e           src_tab [NUM_SRC];
  logic               rx_hit;

  assign rx_hit = data_ready && (!fifo_mode || (rx_level >= rx_trigger));

  // index 0 is the highest priority
  assign req[0] = en[EN_LINE]  && (|line_err);
  assign req[1] = en[EN_RX]    && char_tmo;
  assign req[2] = en[EN_RX]    && rx_hit;
  assign req[3] = en[EN_THRE]  && thre_pend;
  assign req[4] = en[EN_MODEM] && (|modem_delta);

  assign src_tab[0] = SRC_LINE;
  assign src_tab[1] = SRC_TIMEOUT;
  assign src_tab[2] = SRC_RXDATA;
  assign src_tab[3] = SRC_THRE;
  assign src_tab[4] = SRC_MODEM;

  always_comb begin
    code = SRC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i])
        code = src_tab[i];
    end
  end

endmodule

// File: rtl/uart_irq_idreg.sv
module uart_irq_idreg
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fifo_mode,
  input  irq_src_e code,
  output logic [7:0] iid_q,
  output logic       irq_q
);

  logic [7:0] iid_d;
  logic       irq_d;

  always_comb begin
    iid_d = {{2{fifo_mode}}, 2'b00, code};
    irq_d = (code != SRC_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iid_q <= {4'h0, SRC_NONE};
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= irq_d;
    end
  end

  p_mode_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> iid_q[7:6] == {2{$past(fifo_mode)}} && iid_q[5:4] == 2'b00);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int unsigned RX_CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ier_wr_en,
  input  logic [7:0]          ier_wr_data,
  input  logic                iid_rd_en,
  input  logic                fifo_mode,
  input  logic [3:0]          line_err,
  input  logic                data_ready,
  input  logic [RX_CNT_W-1:0] rx_level,
  input  logic [RX_CNT_W-1:0] rx_trigger,
  input  logic                char_tmo,
  input  logic                thr_write,
  input  logic                thr_empty,
  input  logic                thr_empty_set,
  input  logic [3:0]          modem_delta,
  output logic [7:0]          ier_rdata,
  output logic [7:0]          iid_rdata,
  output logic                irq
);

  localparam int unsigned ERR_W   = 4;
  localparam int unsigned DELTA_W = 4;

  logic [EN_W-1:0] en_q;
  logic            pend_q;
  logic            rd_clr;
  irq_src_e        code;
  logic            unused_hi;

  assign unused_hi = ^ier_wr_data[7:EN_W];
  assign rd_clr    = iid_rd_en && (iid_rdata[3:0] == SRC_THRE);

  uart_irq_enable u_enable (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (ier_wr_en),
    .wr_data       (ier_wr_data[EN_W-1:0]),
    .rd_clr        (rd_clr),
    .thr_write     (thr_write),
    .thr_empty     (thr_empty),
    .thr_empty_set (thr_empty_set),
    .en_q          (en_q),
    .pend_q        (pend_q)
  );

  uart_irq_prio #(
    .RX_CNT_W (RX_CNT_W),
    .ERR_W    (ERR_W),
    .DELTA_W  (DELTA_W)
  ) u_prio (
    .en          (en_q),
    .thre_pend   (pend_q),
    .line_err    (line_err),
    .data_ready  (data_ready),
    .fifo_mode   (fifo_mode),
    .rx_level    (rx_level),
    .rx_trigger  (rx_trigger),
    .char_tmo    (char_tmo),
    .modem_delta (modem_delta),
    .code        (code)
  );

  uart_irq_idreg u_idreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .code      (code),
    .iid_q     (iid_rdata),
    .irq_q     (irq)
  );

  assign ier_rdata = {{(8-EN_W){1'b0}}, en_q};

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iid_rdata[3:0] != SRC_NONE));

  p_line_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_rdata[EN_LINE] && (|line_err)) |=> iid_rdata[3:0] == SRC_LINE);

  p_tmo_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_rdata[EN_RX] |=> (iid_rdata[3:0] != SRC_TIMEOUT) && (iid_rdata[3:0] != SRC_RXDATA));

  p_rx_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && (rx_level < rx_trigger) && !char_tmo) |=> iid_rdata[3:0] != SRC_RXDATA);

endmodule

// File: tb/uart_irq_arbiter_tb_top.sv
module uart_irq_arbiter_tb_top;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ier_wr_en, iid_rd_en, fifo_mode, data_ready, char_tmo;
  logic          thr_write, thr_empty, thr_empty_set;
  logic [7:0]    ier_wr_data;
  logic [3:0]    line_err, modem_delta;
  logic [CW-1:0] rx_level, rx_trigger;
  logic [7:0]    ier_rdata, iid_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  // reference state
  logic [3:0] m_ier;
  logic       m_pend;
  logic [7:0] m_iid;
  logic       m_irq;

  always #10 clk = ~clk;

  uart_irq_arbiter #(.RX_CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ier_wr_en(ier_wr_en), .ier_wr_data(ier_wr_data),
    .iid_rd_en(iid_rd_en), .fifo_mode(fifo_mode), .line_err(line_err),
    .data_ready(data_ready), .rx_level(rx_level), .rx_trigger(rx_trigger),
    .char_tmo(char_tmo), .thr_write(thr_write), .thr_empty(thr_empty),
    .thr_empty_set(thr_empty_set), .modem_delta(modem_delta),
    .ier_rdata(ier_rdata), .iid_rdata(iid_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_code();
    if (m_ier[2] && line_err != 0) return 4'h6;
    if (m_ier[0] && char_tmo) return 4'hC;
    if (m_ier[0] && data_ready && (!fifo_mode || rx_level >= rx_trigger)) return 4'h4;
    if (m_ier[1] && m_pend) return 4'h2;
    if (m_ier[3] && modem_delta != 0) return 4'h0;
    return 4'h1;
  endfunction

  task automatic step();
    logic [3:0] c;
    logic       p;
    @(posedge clk);
    if (!rst_n) begin
      m_ier = 0; m_pend = 0; m_iid = 8'h01; m_irq = 0;
    end else begin
      c = ref_code();
      p = m_pend;
      if (iid_rd_en && m_iid[3:0] == 4'h2) p = 0;
      if (ier_wr_en && ier_wr_data[1] != m_ier[1]) p = ier_wr_data[1] & thr_empty;
      if (thr_write) p = 0;
      if (thr_empty_set) p = 1;
      m_pend = p;
      if (ier_wr_en) m_ier = ier_wr_data[3:0];
      m_iid = {{2{fifo_mode}}, 2'b00, c};
      m_irq = (c != 4'h1);
    end
    @(negedge clk);
    chk(cur_req, {24'h0, ier_rdata}, {28'h0, m_ier});
    chk(cur_req, {24'h0, iid_rdata}, {24'h0, m_iid});
    chk(cur_req, {31'h0, irq}, {31'h0, m_irq});
    ier_wr_en = 0; iid_rd_en = 0; thr_write = 0; thr_empty_set = 0;
  endtask

  task automatic wr_ier(logic [7:0] v);
    ier_wr_en = 1; ier_wr_data = v;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ier_wr_en = 0; ier_wr_data = 0; iid_rd_en = 0; fifo_mode = 0;
    line_err = 0; data_ready = 0; rx_level = 0; rx_trigger = 0; char_tmo = 0;
    thr_write = 0; thr_empty = 1; thr_empty_set = 0; modem_delta = 0;
    m_ier = 0; m_pend = 0; m_iid = 8'h01; m_irq = 0;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    step();
    // R10 reset values
    chk("R10", {24'h0, iid_rdata}, 32'h01);
    chk("R10", {24'h0, ier_rdata}, 32'h00);
    chk("R10", {31'h0, irq}, 32'h0);

    // R8 upper enable bits dropped
    cur_req = "R8";
    wr_ier(8'hFF);
    chk("R8", {24'h0, ier_rdata}, 32'h0F);
    wr_ier(8'h00);
    step();

    // R1 R2 R9 priority ladder, R5 read clear
    cur_req = "R1";
    line_err = 4'b0100; char_tmo = 1; data_ready = 1; modem_delta = 4'b0010;
    wr_ier(8'h0F);
    step();
    chk("R2", {24'h0, iid_rdata}, 32'h06);
    line_err = 0; step();
    chk("R2", {24'h0, iid_rdata}, 32'h0C);
    char_tmo = 0; step();
    chk("R2", {24'h0, iid_rdata}, 32'h04);
    data_ready = 0; step();
    chk("R2", {24'h0, iid_rdata}, 32'h02);
    cur_req = "R5";
    iid_rd_en = 1; step();
    step();
    chk("R5", {24'h0, iid_rdata}, 32'h00);
    cur_req = "R9";
    modem_delta = 0; step();
    chk("R9", {24'h0, iid_rdata}, 32'h01);
    chk("R9", {31'h0, irq}, 32'h0);

    // R3 R4 trigger threshold in queue mode
    cur_req = "R3";
    wr_ier(8'h01);
    fifo_mode = 1; data_ready = 1; rx_level = 3; rx_trigger = 4;
    step(); step();
    chk("R4", {24'h0, iid_rdata}, 32'hC1);
    chk("R3", {31'h0, irq}, 32'h0);
    rx_level = 4; step();
    chk("R3", {24'h0, iid_rdata}, 32'hC4);
    rx_level = 5; step();
    chk("R3", {24'h0, iid_rdata}, 32'hC4);
    fifo_mode = 0; rx_level = 0; step();
    chk("R3", {24'h0, iid_rdata}, 32'h04);

    // R11 timeout masked by enable bit 0
    cur_req = "R11";
    char_tmo = 1;
    wr_ier(8'h00);
    step();
    chk("R11", {24'h0, iid_rdata}, 32'h01);
    wr_ier(8'h01);
    step();
    chk("R11", {24'h0, iid_rdata}, 32'h0C);
    char_tmo = 0; data_ready = 0; step();

    // R6 enable flip behaviour
    cur_req = "R6";
    thr_empty = 1;
    wr_ier(8'h02);
    step();
    chk("R6", {24'h0, iid_rdata}, 32'h02);
    wr_ier(8'h03);
    step();
    chk("R6", {24'h0, iid_rdata}, 32'h02);
    wr_ier(8'h00);
    thr_empty = 0;
    wr_ier(8'h02);
    step();
    chk("R6", {24'h0, iid_rdata}, 32'h01);

    // R7 holding write and became-empty events
    cur_req = "R7";
    thr_empty_set = 1; step();
    step();
    chk("R7", {24'h0, iid_rdata}, 32'h02);
    thr_write = 1; step();
    step();
    chk("R7", {24'h0, iid_rdata}, 32'h01);
    thr_write = 1; thr_empty_set = 1; step();
    step();
    chk("R7", {24'h0, iid_rdata}, 32'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule